// File: doc/BRIEF.md
# Table-driven repeating sequence generator

This block steps through a programmable pattern of output values and then starts the pattern again. Values may appear more than once within one period. Examples are 0,0,1,1,2,2,3,3 and 0,1,0,2,0,3. A step counter keeps track of the position. A separate lookup table, held in registers, maps each position to an output value. Two positions that show the same value but lead to different next positions are therefore still different states.

Each table word has three fields. The first is the value to show. The second is a finish flag: when it is set, the counter returns to zero on the step that reads the word. The third is a next-page field. The page register loads it on a finished step, and the page then acts as the upper address bits. Together these let the table set any period length, and let one sub-pattern follow another.

The step taken each clock has one of four names:
- HOLD: enable is low.
- NEXT: advance the counter by one.
- ROLL: natural wrap from the top count to zero.
- TERM: finish flag set; clear the counter and load the page.

Software fills the table through a simple write port.

Top module: `seqgen_top`

## Requirements
- R1: Synchronous reset clears the step counter, the page register and the output register to zero.
- R2: On an enabled clock the output register takes the value field of the word addressed before that clock, so the output trails the address by one clock.
- R3: On an enabled clock without a finish flag, the counter advances by one (NEXT). From its top count 2^CW-1 it wraps to zero (ROLL), which gives a default period of 2^CW steps.
- R4: On an enabled clock whose word has the finish flag set (TERM), the counter becomes zero and the page register loads the word's next-page field.
- R5: The page register changes only on a TERM step.
- R6: While enable is low (HOLD), the counter, the page and the output all keep their values.
- R7: A write strobe replaces the addressed word at the next clock. A read in the same clock as the write still sees the old word.
- R8: Writes made while enable is low do not move the counter, the page or the output.
- R9: Word layout is bits [OW-1:0] value, bit OW finish flag, bits [OW+PW:OW+1] next page. The table address is {page, counter}. Defaults are CW=3, PW=1 and OW=4, giving 16 words of 6 bits.
- R10: Reset clears every table word to zero. An unwritten table therefore gives a constant zero output with period 2^CW.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | CW+PW | Table word address {page, counter} |
| wr_data | input | PW+1+OW | Word {next page, finish, value} |
| dout | output | OW | Registered sequence value |

## Verification
The assertions take for granted that enable and the write strobe are always known after reset. They also take for granted that the write address and data are known whenever the strobe is high, because the write check indexes the table with the past address.

The stimulus meets these assumptions by driving every input to a defined value on the falling edge, from reset onward. It lowers the strobe whenever no write is wanted. The stimulus also covers patterns that wrap naturally, patterns that finish early, switching between pages, and enable held low. It writes to the very word being read, to show that a read in the same clock as a write returns the old word.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;
    // Default geometry of the generator
    localparam int DEF_CW = 3;
    localparam int DEF_PW = 1;
    localparam int DEF_OW = 4;

    // Kind of step taken on a clock
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_NEXT = 2'd1,
        STEP_ROLL = 2'd2,
        STEP_TERM = 2'd3
    } step_e;
endpackage

// File: rtl/seqgen_table.sv
module seqgen_table #(
    parameter int AW = 4,
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_word
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // One register word per entry; reset clears each, write replaces one
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[gi] <= '0;
            end else if (wr_en && (wr_addr == AW'(gi))) begin
                mem[gi] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_word = mem[rd_addr];
    end

    // R7: a strobed word appears at the next clock
    assert_write_lands_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));

    // R10: reset leaves word zero empty
    assert_table_clear_R10: assert property (@(posedge clk)
        rst |=> (mem[0] == '0));
endmodule

// File: rtl/seqgen_ctrl.sv
module seqgen_ctrl
    import seqgen_pkg::*;
#(
    parameter int CW = 3,
    parameter int PW = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          fin,
    input  logic [PW-1:0] pg_nxt,
    output logic [CW-1:0] cnt,
    output logic [PW-1:0] page,
    output step_e         step
);
    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    // Step selection
    always_comb begin
        if (!en) begin
            step = STEP_HOLD;
        end else if (fin) begin
            step = STEP_TERM;
        end else if (cnt == TOP) begin
            step = STEP_ROLL;
        end else begin
            step = STEP_NEXT;
        end
    end

    // Position state register
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            page <= '0;
        end else begin
            unique case (step)
                STEP_HOLD: begin
                    cnt  <= cnt;
                    page <= page;
                end
                STEP_NEXT: begin
                    cnt  <= cnt + 1'b1;
                end
                STEP_ROLL: begin
                    cnt  <= '0;
                end
                STEP_TERM: begin
                    cnt  <= '0;
                    page <= pg_nxt;
                end
                default: begin
                    cnt  <= '0;
                    page <= '0;
                end
            endcase
        end
    end

    assert_reset_pos_R1: assert property (@(posedge clk)
        rst |=> (cnt == '0 && page == '0));

    assert_step_adv_R3: assert property (@(posedge clk) disable iff (rst)
        (en && !fin) |=> (cnt == CW'($past(cnt) + 1'b1)));

    assert_term_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (en && fin) |=> (cnt == '0 && page == $past(pg_nxt)));

    assert_page_steady_R5: assert property (@(posedge clk) disable iff (rst)
        !(en && fin) |=> $stable(page));

    assert_hold_pos_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(cnt) && $stable(page)));
endmodule

// File: rtl/seqgen_out.sv
module seqgen_out #(
    parameter int OW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [OW-1:0] val,
    output logic [OW-1:0] dout
);
    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (en) begin
            dout <= val;
        end
    end

    assert_out_reset_R1: assert property (@(posedge clk)
        rst |=> (dout == '0));

    assert_out_follow_R2: assert property (@(posedge clk) disable iff (rst)
        en |=> (dout == $past(val)));

    assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(dout));
endmodule

// File: rtl/seqgen_top.sv
module seqgen_top
    import seqgen_pkg::*;
#(
    parameter int CW = DEF_CW,
    parameter int PW = DEF_PW,
    parameter int OW = DEF_OW,
    localparam int AW = CW + PW,
    localparam int DW = PW + 1 + OW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [OW-1:0] dout
);
    localparam int FIN_BIT = OW;
    localparam int PG_LO   = OW + 1;

    logic [CW-1:0] cnt;
    logic [PW-1:0] page;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_word;
    logic [OW-1:0] w_val;
    logic          w_fin;
    logic [PW-1:0] w_pg;
    step_e         step;

    // Table address and word fields
    always_comb begin
        rd_addr = {page, cnt};
        w_val   = rd_word[OW-1:0];
        w_fin   = rd_word[FIN_BIT];
        w_pg    = rd_word[PG_LO +: PW];
    end

    seqgen_table #(.AW(AW), .DW(DW)) u_table (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_word(rd_word)
    );

    seqgen_ctrl #(.CW(CW), .PW(PW)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .fin   (w_fin),
        .pg_nxt(w_pg),
        .cnt   (cnt),
        .page  (page),
        .step  (step)
    );

    seqgen_out #(.OW(OW)) u_out (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .val (w_val),
        .dout(dout)
    );

    // R8: a write with enable low leaves the address where it was
    assert_write_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !en) |=> $stable(rd_addr));

    // R5: a changed page means the previous step was TERM
    assert_page_term_R5: assert property (@(posedge clk) disable iff (rst)
        (step != STEP_TERM) |=> (page == $past(page)));
endmodule

// File: tb/sim_seqgen_top.sv
`timescale 1ns/1ps
module sim_seqgen_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [5:0] wr_data = '0;
    logic [3:0] dout;

    int checks = 0;
    int failures = 0;
    int tbl [16];
    int m_cnt = 0;
    int m_page = 0;
    int m_dout = 0;

    always #2 clk = ~clk;

    seqgen_top u0 (
        .clk(clk), .rst(rst), .en(en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .dout(dout)
    );

    function automatic int mk(int v, int f, int p);
        return (v & 15) | ((f & 1) << 4) | ((p & 1) << 5);
    endfunction

    task automatic check(string req);
        checks++;
        if (int'(dout) != m_dout) begin
            failures++;
            $display("FAIL %s dout=%0d expected=%0d", req, dout, m_dout);
        end
    endtask

    // One clock of stimulus, model update and comparison
    task automatic tick(bit r, bit e, bit we, int wa, int wd, string req);
        int w;
        rst = r; en = e; wr_en = we; wr_addr = 4'(wa); wr_data = 6'(wd);
        @(posedge clk);
        if (r) begin
            m_cnt = 0; m_page = 0; m_dout = 0;
            for (int i = 0; i < 16; i++) tbl[i] = 0;
        end else begin
            if (e) begin
                w = tbl[m_page * 8 + m_cnt];
                m_dout = w & 15;
                if (((w >> 4) & 1) == 1) begin
                    m_cnt = 0;
                    m_page = (w >> 5) & 1;
                end else begin
                    m_cnt = (m_cnt + 1) % 8;
                end
            end
            if (we) tbl[wa] = wd;
        end
        @(negedge clk);
        check(req);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 and R10: reset state, then an empty table yields zeros
        tick(1, 0, 0, 0, 0, "R1");
        tick(1, 0, 0, 0, 0, "R1");
        for (int i = 0; i < 10; i++) tick(0, 1, 0, 0, 0, "R10");

        // R8/R9: load 0,0,1,1,2,2,3,3 into page 0 while idle
        for (int i = 0; i < 8; i++) tick(0, 0, 1, i, mk(i >> 1, 0, 0), "R8");
        // R2/R3: natural wrap, period eight
        for (int i = 0; i < 20; i++) tick(0, 1, 0, 0, 0, "R3");

        // R4/R5: page 0 is 0,1,0,2,0,3 and finishes into page 1; page 1 is 9,8,7
        for (int i = 0; i < 6; i++) begin
            int v;
            v = (i % 2 == 0) ? 0 : (i / 2 + 1);
            tick(0, 0, 1, i, mk(v, (i == 5) ? 1 : 0, 1), "R8");
        end
        tick(0, 0, 1, 8, mk(9, 0, 0), "R8");
        tick(0, 0, 1, 9, mk(8, 0, 0), "R8");
        tick(0, 0, 1, 10, mk(7, 1, 0), "R8");
        for (int i = 0; i < 30; i++) tick(0, 1, 0, 0, 0, "R4");

        // R6: enable toggling holds everything on idle clocks
        for (int i = 0; i < 24; i++) tick(0, (i % 3) != 0, 0, 0, 0, "R6");

        // R7: overwrite the word currently being read
        for (int i = 0; i < 10; i++) begin
            tick(0, 1, 1, m_page * 8 + m_cnt, mk(15 - i, 0, 0), "R7");
            tick(0, 1, 0, 0, 0, "R7");
        end
        for (int i = 0; i < 12; i++) tick(0, 1, 0, 0, 0, "R5");

        // R1: reset while running
        tick(1, 1, 0, 0, 0, "R1");
        for (int i = 0; i < 10; i++) tick(0, 1, 0, 0, 0, "R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule